// File: doc/BRIEF.md
# Eulerian Neighborhood Transition Sequencer

This block drives pattern-sensitivity testing of a small group of K memory cells. It walks a closed tour over the K-dimensional hypercube whose nodes are the 2^K possible contents of the group. Each directed edge of the hypercube changes exactly one cell, either from 0 to 1 or from 1 to 0. The tour uses every one of the K·2^K directed edges once. As a result, every rising and every falling transition of every cell is exercised under every combination of the other cells.

The tour starts and ends at the all-zero group. The tour is found in hardware with a visited-edge bitmap and an explicit node stack, following Hierholzer's method. Each unit of work has two phases. First, a write step names the cell to toggle and gives the new group value; a memory model takes it with a valid/ready handshake. Second, a read-back request asks for all K cells; the block compares the returned data with the expected group value and flags any difference. The block does not map cells onto physical addresses.

Top module: `euler_nbhd_seq`

## Requirements
- R1: After reset, done, step_valid and chk_req are low, and no step is presented until start is pulsed.
- R2: After a start, exactly K·2^K write steps are accepted before done rises; done stays high until the next start.
- R3: Each step toggles one cell: step_value equals the previous group value with bit step_cell (bit 0 is cell 0) inverted. The first step starts from the all-zero group.
- R4: Over one run, each pair (group value before the step, step_cell) occurs exactly once, so every directed single-cell transition is covered.
- R5: When done rises, the last accepted step_value is all-zero.
- R6: While step_valid is high and step_ready is low, step_valid, step_cell and step_value hold.
- R7: After each accepted step, chk_req is high with chk_expect equal to the accepted step_value until rd_valid. No step is presented while chk_req is high.
- R8: mismatch is high in exactly those cycles where chk_req and rd_valid are high and rd_data differs from chk_expect.
- R9: start is ignored while a run is in progress. start given while done is high begins a fresh run from the all-zero group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (from idle or done) |
| step_valid | output | 1 | A write step is presented |
| step_ready | input | 1 | Memory takes the presented step |
| step_cell | output | max(1,clog2 K) | Index of the cell to toggle |
| step_value | output | K | Group value after the toggle |
| chk_req | output | 1 | Read-back of all K cells requested |
| chk_expect | output | K | Expected read-back value |
| rd_valid | input | 1 | Read-back data is present |
| rd_data | input | K | Read-back data of the K cells |
| mismatch | output | 1 | Read-back differs from expectation |
| done | output | 1 | Tour complete |

## Verification
Assertions watch every cycle for the single-cell toggle relation between successive steps, the hold of a stalled step, the exclusion of write and read phases, the all-zero group at completion, and the stack and bitmap staying inside their bounds with no edge marked twice. Only the bench scenarios can show the whole-run properties: the exact step count, coverage of every directed edge exactly once, detection of a corrupted read-back, a start ignored in mid-run, and a clean restart after completion under different stall patterns.

// File: rtl/euler_seq_pkg.sv
package euler_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WALK  = 3'd1,
    ST_EMIT  = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/free_arc_pick.sv
// Lowest-set-bit picker, used for free-edge choice and for decoding a one-hot difference.
module free_arc_pick #(
  parameter int W  = 3,
  parameter int IW = 2
) (
  input  logic [W-1:0]  mask,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/arc_bitmap.sv
// One flag per directed edge (node, cell); set once an edge has been walked.
module arc_bitmap #(
  parameter int K  = 3,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          mark_en,
  input  logic [K-1:0]  mark_node,
  input  logic [CW-1:0] mark_cell,
  input  logic [K-1:0]  query_node,
  output logic [K-1:0]  free_mask
);
  localparam int NODES = 1 << K;

  logic [NODES-1:0][K-1:0] used_q, used_d;

  always_comb begin
    used_d = used_q;
    if (clear) used_d = '0;
    else if (mark_en) used_d[mark_node][mark_cell] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else if (clear || mark_en) used_q <= used_d;
  end

  assign free_mask = ~used_q[query_node];

  // R4: an edge is never walked twice in one run
  a_r4_arc_once: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !clear) |-> !used_q[mark_node][mark_cell]);
endmodule

// File: rtl/arc_stack.sv
// LIFO of hypercube nodes for the tour search.
module arc_stack #(
  parameter int K     = 3,
  parameter int DEPTH = 25,
  parameter int SPW   = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init,
  input  logic           push,
  input  logic           pop,
  input  logic [K-1:0]   push_data,
  output logic [K-1:0]   top,
  output logic [K-1:0]   below,
  output logic [SPW-1:0] depth
);
  logic [DEPTH-1:0][K-1:0] mem;
  logic [SPW-1:0] sp_q, sp_d;
  logic [SPW-1:0] sp_m1, sp_m2;

  assign sp_m1 = sp_q - SPW'(1);
  assign sp_m2 = sp_q - SPW'(2);

  always_comb begin
    sp_d = sp_q;
    if (init) sp_d = SPW'(1);
    else if (push) sp_d = sp_q + SPW'(1);
    else if (pop) sp_d = sp_m1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else if (init || push || pop) sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (init) mem[0] <= '0;
    else if (push) mem[sp_q] <= push_data;
  end

  assign top   = mem[sp_m1];
  assign below = mem[sp_m2];
  assign depth = sp_q;

  // R2: the stack stays inside its storage for a full tour
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !init) |-> (sp_q < SPW'(DEPTH)));
  a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !init) |-> (sp_q != '0));
endmodule

// File: rtl/euler_nbhd_seq.sv
module euler_nbhd_seq
  import euler_seq_pkg::*;
#(
  parameter int K  = 3,
  parameter int CW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          step_valid,
  input  logic          step_ready,
  output logic [CW-1:0] step_cell,
  output logic [K-1:0]  step_value,
  output logic          chk_req,
  output logic [K-1:0]  chk_expect,
  input  logic          rd_valid,
  input  logic [K-1:0]  rd_data,
  output logic          mismatch,
  output logic          done
);
  localparam int NODES = 1 << K;
  localparam int ARCS  = K * NODES;
  localparam int DEPTH = ARCS + 1;
  localparam int SPW   = $clog2(DEPTH + 1);

  seq_state_e state_q, state_d;
  logic [K-1:0]  hold_val_q, hold_val_d;
  logic [CW-1:0] hold_cell_q, hold_cell_d;
  logic [K-1:0]  cur_q, cur_d;

  logic          stk_init, stk_push, stk_pop;
  logic [K-1:0]  stk_top, stk_below, nbr;
  logic [SPW-1:0] stk_depth;
  logic          map_clear, map_mark;
  logic [K-1:0]  free_mask;
  logic          free_any, diff_any;
  logic [CW-1:0] free_idx, diff_idx;

  arc_stack #(.K(K), .DEPTH(DEPTH), .SPW(SPW)) u_stack (
    .clk(clk), .rst_n(rst_n), .init(stk_init), .push(stk_push), .pop(stk_pop),
    .push_data(nbr), .top(stk_top), .below(stk_below), .depth(stk_depth)
  );

  arc_bitmap #(.K(K), .CW(CW)) u_map (
    .clk(clk), .rst_n(rst_n), .clear(map_clear), .mark_en(map_mark),
    .mark_node(stk_top), .mark_cell(free_idx), .query_node(stk_top),
    .free_mask(free_mask)
  );

  free_arc_pick #(.W(K), .IW(CW)) u_pick_free (
    .mask(free_mask), .any(free_any), .idx(free_idx)
  );

  free_arc_pick #(.W(K), .IW(CW)) u_pick_diff (
    .mask(stk_top ^ stk_below), .any(diff_any), .idx(diff_idx)
  );

  assign nbr = stk_top ^ (K'(1) << free_idx);

  always_comb begin
    state_d     = state_q;
    hold_val_d  = hold_val_q;
    hold_cell_d = hold_cell_q;
    cur_d       = cur_q;
    stk_init    = 1'b0;
    stk_push    = 1'b0;
    stk_pop     = 1'b0;
    map_clear   = 1'b0;
    map_mark    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d   = ST_WALK;
          stk_init  = 1'b1;
          map_clear = 1'b1;
          cur_d     = '0;
        end
      end
      ST_WALK: begin
        if (free_any) begin
          map_mark = 1'b1;
          stk_push = 1'b1;
        end else if (stk_depth > SPW'(1)) begin
          stk_pop     = 1'b1;
          hold_val_d  = stk_below;
          hold_cell_d = diff_idx;
          state_d     = ST_EMIT;
        end else begin
          stk_pop = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_EMIT: begin
        if (step_ready) begin
          cur_d   = hold_val_q;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (rd_valid) state_d = ST_WALK;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      hold_val_q  <= '0;
      hold_cell_q <= '0;
      cur_q       <= '0;
    end else begin
      state_q <= state_d;
      if (stk_pop) begin
        hold_val_q  <= hold_val_d;
        hold_cell_q <= hold_cell_d;
      end
      if (stk_init || (step_valid && step_ready)) cur_q <= cur_d;
    end
  end

  assign step_valid = (state_q == ST_EMIT);
  assign chk_req    = (state_q == ST_CHECK);
  assign done       = (state_q == ST_DONE);
  assign step_cell  = hold_cell_q;
  assign step_value = hold_val_q;
  assign chk_expect = hold_val_q;
  assign mismatch   = chk_req && rd_valid && (rd_data != hold_val_q);

  // R3: a presented step toggles exactly the named cell of the current group
  a_r3_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> (step_value == (cur_q ^ (K'(1) << step_cell))));
  // R3: a backtrack pop always crosses a single hypercube edge
  a_r3_pop_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WALK && state_d == ST_EMIT) |-> diff_any);
  // R6: stalled step holds
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !step_ready) |=> (step_valid && $stable(step_value) && $stable(step_cell)));
  // R7: write and read phases never overlap
  a_r7_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_valid && chk_req));
  // R5: the tour closes on the all-zero group
  a_r5_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cur_q == '0));
  // R1: nothing is requested once the tour is complete
  a_r1_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!step_valid && !chk_req && !mismatch));
endmodule

// File: tb/euler_nbhd_seq_bench.sv
`timescale 1ns/1ps
module euler_nbhd_seq_bench;
  localparam int K     = 3;
  localparam int CW    = (K > 1) ? $clog2(K) : 1;
  localparam int NARC  = K * (1 << K);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          step_ready = 1'b0;
  logic          rd_valid = 1'b0;
  logic [K-1:0]  rd_data = '0;
  logic          step_valid, chk_req, mismatch, done;
  logic [CW-1:0] step_cell;
  logic [K-1:0]  step_value, chk_expect;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  euler_nbhd_seq #(.K(K)) u_euler_nbhd_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .step_valid(step_valid), .step_ready(step_ready),
    .step_cell(step_cell), .step_value(step_value),
    .chk_req(chk_req), .chk_expect(chk_expect),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mismatch(mismatch), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // R1: quiet after reset and while idle
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!done && !step_valid && !chk_req, "R1", "outputs after reset",
          int'({done, step_valid, chk_req}), 0);
    repeat (6) @(negedge clk);
    check(!done && !step_valid && !chk_req, "R1", "idle without start",
          int'({done, step_valid, chk_req}), 0);
  endtask

  // One full tour; stall slows both handshakes, bad_read corrupts that read-back,
  // poke_cyc gives a start pulse in mid-run (R9).
  task automatic t_run(input bit stall, input int bad_read, input int poke_cyc);
    int steps = 0;
    int reads = 0;
    logic [K-1:0]  cur = '0;
    logic [NARC-1:0] seen = '0;
    bit pend = 1'b0;
    bit fin = 1'b0;
    logic [CW-1:0] h_cell = '0;
    logic [K-1:0]  h_val = '0;
    pulse_start();
    for (int cyc = 0; cyc < 4000 && !fin; cyc++) begin
      @(negedge clk);
      step_ready = 1'b0;
      rd_valid   = 1'b0;
      start      = (cyc == poke_cyc);
      if (done) begin
        fin = 1'b1;
      end else begin
        if (pend)
          check(step_valid && step_cell == h_cell && step_value == h_val, "R6",
                "stalled step held", int'(step_value), int'(h_val));
        pend = 1'b0;
        if (step_valid) begin
          if (stall && (cyc % 3) != 0) begin
            pend = 1'b1; h_cell = step_cell; h_val = step_value;
          end else begin
            check(step_value == (cur ^ (K'(1) << step_cell)), "R3",
                  "single-cell toggle", int'(step_value), int'(cur ^ (K'(1) << step_cell)));
            check(!seen[int'(cur) * K + int'(step_cell)], "R4", "edge not repeated",
                  1, 0);
            seen[int'(cur) * K + int'(step_cell)] = 1'b1;
            cur = step_value;
            steps++;
            step_ready = 1'b1;
          end
        end
        if (chk_req) begin
          check(!step_valid, "R7", "no step during read-back", int'(step_valid), 0);
          check(chk_expect == cur, "R7", "read-back expectation", int'(chk_expect), int'(cur));
          if (!(stall && (cyc % 2) != 0)) begin
            reads++;
            rd_valid = 1'b1;
            rd_data  = (reads == bad_read) ? (cur ^ K'(1)) : cur;
            #1;
            check(mismatch == (reads == bad_read), "R8", "mismatch flag",
                  int'(mismatch), int'(reads == bad_read));
          end
        end else begin
          #1;
          check(!mismatch, "R8", "no mismatch without read", int'(mismatch), 0);
        end
      end
    end
    step_ready = 1'b0;
    rd_valid   = 1'b0;
    start      = 1'b0;
    check(fin, "R2", "watchdog: tour finished", int'(fin), 1);
    check(steps == NARC, "R2", "step count", steps, NARC);
    check(reads == NARC, "R7", "read-back count", reads, NARC);
    check(&seen, "R4", "all edges covered", int'($countones(seen)), NARC);
    check(cur == '0, "R5", "final group value", int'(cur), 0);
  endtask

  // R2/R9: done holds while idle; start from done restarts at zero
  task automatic t_hold_done();
    repeat (5) @(negedge clk);
    check(done && !step_valid, "R2", "done held until start", int'(done), 1);
  endtask

  initial begin
    t_reset();
    t_run(1'b0, 0, -1);
    t_hold_done();
    t_run(1'b1, 5, -1);
    t_hold_done();
    t_run(1'b0, 0, 12);
    t_run(1'b1, 0, 40);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule